// File: doc/BRIEF.md
# I2C Control Register with Master Bit-Clock Generator

This block holds the 8-bit control register of an I2C serial unit and produces the bit clock that the master shifter uses to drive SCL. The CPU writes and reads the register over a single-cycle register bus. The serial engine and the bus monitor can also change two of its bits. The serial engine raises the interrupt flag when it needs service. A STOP condition seen on the bus clears the pending stop request. While the unit is disabled, the stop request always reads as zero.

A 3-bit rate code picks the SCL half-period. Seven of the codes divide a 48 MHz reference down to fixed rates from 1200 kHz to 75 kHz; this range covers standard mode (100 kHz) and fast mode (400 kHz). The eighth code makes the clock change level once for each pulse of an external timer overflow. While the unit is disabled the clock generator is held idle. Any change of the rate code makes the generator start a fresh half-period.

Top module: `i2c_ctl_rate`

## Requirements
- R1: After reset the register reads 8'h00 and `scl_clk` is 0.
- R2: A write stores `reg_wdata` and the register reads it back on `reg_rdata`. The bit positions are: bit 7 is rate bit 2, bit 6 is enable, bit 5 is start, bit 4 is stop, bit 3 is the interrupt flag, bit 2 is acknowledge enable, and bits 1:0 are rate bits 1:0. The field outputs follow these positions.
- R3: A pulse on `irq_req` sets bit 3 at the next edge, including when a CPU write in the same cycle tries to clear that bit.
- R4: A pulse on `stop_seen` clears bit 4 at the next edge, including when a CPU write in the same cycle tries to set that bit.
- R5: Bit 4 is never 1 while bit 6 is 0. A write that sets stop with enable at 0 leaves stop at 0.
- R6: With enable at 1 and rate codes 0 to 6, `scl_clk` changes level every 20, 40, 60, 80, 160, 240 or 320 clock cycles respectively (parameter UNIT=20 times 1, 2, 3, 4, 8, 12 or 16). The first change comes one half-period after the write that enables the unit.
- R7: With rate code 7, `scl_clk` changes level at the edge that follows each `tmr_ovf` pulse, and at no other time.
- R8: While enable is 0, `scl_clk` stays at 0.
- R9: A write that changes the rate code restarts the half-period. The next change of `scl_clk` comes one full new half-period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (48 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | input | 1 | Serial-interrupt request pulse |
| stop_seen | input | 1 | STOP-detected pulse from the bus monitor |
| tmr_ovf | input | 1 | External timer-overflow pulse |
| en_o | output | 1 | Unit enable |
| sta_o | output | 1 | Start request |
| sto_o | output | 1 | Stop request |
| si_o | output | 1 | Interrupt flag |
| aa_o | output | 1 | Acknowledge enable |
| rate_o | output | 3 | Rate select code |
| scl_clk | output | 1 | Toggling bit clock for the master shifter |

## Verification
A corrupted register bit shows on `reg_rdata` and on the field outputs at the edge after the event that caused it. This is why each hardware-versus-write collision is read back right after the cycle in which it happens. A divider that loads the wrong value, or that restarts at the wrong time, shows up as a shifted `scl_clk` change. The shift appears within one half-period, at most 320 cycles. The bench therefore counts the exact number of edges between clock changes, both after an enable write and after a rate change. A generator that leaks activity while disabled, or that takes a timer pulse in a divider mode, shows as an `scl_clk` change in a window where the bench expects the clock to stay still.

// File: rtl/i2c_ctl_rate.sv
module i2c_ctl_rate #(
  parameter int UNIT = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_req,
  input  logic       stop_seen,
  input  logic       tmr_ovf,
  output logic       en_o,
  output logic       sta_o,
  output logic       sto_o,
  output logic       si_o,
  output logic       aa_o,
  output logic [2:0] rate_o,
  output logic       scl_clk
);
  localparam int CW = $clog2(UNIT * 16 + 1);

  logic [7:0]    ctl_q, ctl_d;
  logic [CW-1:0] cnt_q, half;
  logic          scl_q;
  logic [2:0]    rate_q, rate_d;
  logic          restart;

  always_comb begin
    ctl_d = reg_wr ? reg_wdata : ctl_q;
    if (irq_req) ctl_d[3] = 1'b1;
    if (stop_seen || !ctl_d[6]) ctl_d[4] = 1'b0;
  end

  assign rate_q  = {ctl_q[7], ctl_q[1:0]};
  assign rate_d  = {ctl_d[7], ctl_d[1:0]};
  assign restart = (rate_d != rate_q) || !ctl_q[6];

  always_comb begin
    case (rate_q)
      3'd0:    half = CW'(UNIT);
      3'd1:    half = CW'(UNIT * 2);
      3'd2:    half = CW'(UNIT * 3);
      3'd3:    half = CW'(UNIT * 4);
      3'd4:    half = CW'(UNIT * 8);
      3'd5:    half = CW'(UNIT * 12);
      default: half = CW'(UNIT * 16);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      scl_q <= 1'b0;
    end else if (!ctl_d[6]) begin
      cnt_q <= '0;
      scl_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (rate_q == 3'd7) begin
      cnt_q <= '0;
      if (tmr_ovf) scl_q <= ~scl_q;
    end else if (cnt_q == half - 1'b1) begin
      cnt_q <= '0;
      scl_q <= ~scl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign reg_rdata = ctl_q;
  assign en_o      = ctl_q[6];
  assign sta_o     = ctl_q[5];
  assign sto_o     = ctl_q[4];
  assign si_o      = ctl_q[3];
  assign aa_o      = ctl_q[2];
  assign rate_o    = rate_q;
  assign scl_clk   = scl_q;

  assert_si_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> si_o);

  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sto_o);

  assert_sto_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sto_o |-> en_o);

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half);

  assert_ovf_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && rate_o == 3'd7 && tmr_ovf && !reg_wr) |=> (scl_clk != $past(scl_clk)));

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && rate_o == 3'd7 && !tmr_ovf && !reg_wr) |=> $stable(scl_clk));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !scl_clk);
endmodule

// File: tb/test_i2c_ctl_rate.sv
module test_i2c_ctl_rate;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, irq_req = 1'b0, stop_seen = 1'b0, tmr_ovf = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic en_o, sta_o, sto_o, si_o, aa_o, scl_clk;
  logic [2:0] rate_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_ctl_rate i_i2c_ctl_rate (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic measure(output int n);
    logic old = scl_clk;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (scl_clk == old && n < 2000);
  endtask

  function automatic int exp_half(input int code);
    int m[7] = '{1, 2, 3, 4, 8, 12, 16};
    return 20 * m[code];
  endfunction

  task automatic t_reset();
    chk(reg_rdata == 8'h00, "R1 reset register", reg_rdata, 0);
    chk(scl_clk == 1'b0, "R1 reset scl", scl_clk, 0);
  endtask

  task automatic t_fields();
    wr(8'hE6);
    chk(reg_rdata == 8'hE6, "R2 readback", reg_rdata, 8'hE6);
    chk({en_o, sta_o, sto_o, si_o, aa_o, rate_o} == {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'b110},
        "R2 field outputs", {en_o, sta_o, sto_o, si_o, aa_o, rate_o}, 8'b11001110);
    wr(8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    chk(si_o == 1'b1, "R3 irq sets flag", si_o, 1);
    reg_wr = 1'b1; reg_wdata = 8'h00; irq_req = 1'b1;
    @(negedge clk); reg_wr = 1'b0; irq_req = 1'b0;
    chk(reg_rdata == 8'h08, "R3 irq beats write", reg_rdata, 8'h08);
    wr(8'h00);
    chk(si_o == 1'b0, "R3 write clears flag", si_o, 0);
  endtask

  task automatic t_stop();
    wr(8'h50);
    chk(sto_o == 1'b1, "R4 stop set by write", sto_o, 1);
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    chk(sto_o == 1'b0, "R4 stop cleared by bus", sto_o, 0);
    reg_wr = 1'b1; reg_wdata = 8'h50; stop_seen = 1'b1;
    @(negedge clk); reg_wr = 1'b0; stop_seen = 1'b0;
    chk(reg_rdata == 8'h40, "R4 bus stop beats write", reg_rdata, 8'h40);
    wr(8'h10);
    chk(reg_rdata == 8'h00, "R5 stop without enable", reg_rdata, 0);
    wr(8'h50);
    wr(8'h10);
    chk(sto_o == 1'b0, "R5 disabling clears stop", sto_o, 0);
  endtask

  task automatic t_rates();
    int n;
    for (int c = 0; c < 7; c++) begin
      wr(8'h00);
      wr({c[2], 1'b1, 4'b0000, c[1:0]});
      measure(n);
      chk(n == exp_half(c), $sformatf("R6 first half code %0d", c), n, exp_half(c));
      measure(n);
      chk(n == exp_half(c), $sformatf("R6 half period code %0d", c), n, exp_half(c));
    end
  endtask

  task automatic t_timer();
    bit moved = 0;
    wr(8'h00);
    wr(8'hC3);
    repeat (50) begin
      @(posedge clk); #1;
      if (scl_clk) moved = 1;
    end
    chk(!moved, "R7 no toggle without overflow", moved, 0);
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    chk(scl_clk == 1'b1, "R7 toggle on overflow", scl_clk, 1);
    repeat (5) @(negedge clk);
    tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
    chk(scl_clk == 1'b0, "R7 second overflow", scl_clk, 0);
  endtask

  task automatic t_idle();
    bit moved = 0;
    wr(8'h40);
    repeat (30) @(negedge clk);
    wr(8'h03);
    chk(scl_clk == 1'b0, "R8 low after disable", scl_clk, 0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tmr_ovf = i[0];
      if (scl_clk) moved = 1;
    end
    tmr_ovf = 1'b0;
    chk(!moved, "R8 idle while disabled", moved, 0);
  endtask

  task automatic t_restart();
    int n;
    wr(8'h00);
    wr(8'h40);
    repeat (10) @(negedge clk);
    wr(8'h41);
    measure(n);
    chk(n == 40, "R9 restart on rate change", n, 40);
    measure(n);
    chk(n == 40, "R9 new half period", n, 40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_irq();
    t_stop();
    t_rates();
    t_timer();
    t_idle();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule